// File: doc/BRIEF.md
# Column Readout Phase Sequencer

This block produces the per-row switch controls for a column correlated-double-sampling amplifier whose gain is set per column to 1 or 8. A single row-start pulse starts a fixed chain of nine phases. First the pixel reset strobe is pulsed. Then comes a programmable gap. Row select then rises, and the reset level is sampled through the closed input switch. The input switch then opens to isolate the amplifier, and the transfer gate pulses. The gain decision follows, then the feedback-capacitor selection. The input switch closes again for amplification, and the row ends with a sample-and-hold strobe.

Because the input switch opens before charge transfer, the signal level reaches only the comparator first. A comparator bit per column is captured once, at the close of the decision phase. It becomes a 1-bit gain code that drives that column's gain-8 feedback selection and stays on the outputs beside the held sample for horizontal scanning. The length of every phase comes from its own field of a packed length vector. The analog circuits are not modelled.

Top module: `col_readout_seq`

## Requirements
- R1: After reset, and while idle, every strobe output is 0, every gain code and feedback select is 0 (gain 1), and busy_o is 0.
- R2: An accepted row start runs phases 0..8 in this order. 0 has pix_rst_o high. 1 is a gap with all strobes low. 2 has row_sel_o and in_sw_o high. 3 has row_sel_o only. 4 has row_sel_o and tx_o high. 5 (decision) has row_sel_o only. 6 (feedback select) has row_sel_o only. 7 has row_sel_o and in_sw_o high. 8 has row_sel_o and sh_o high. The block then returns to idle.
- R3: Phase k lasts the number of cycles in phase_len_i[k*CNT_W +: CNT_W]. A field value of 0 acts as 1.
- R4: row_sel_o rises exactly the phase-1 length (at least one cycle) after pix_rst_o falls.
- R5: in_sw_o is low in every cycle in which tx_o is high.
- R6: cmp_i[c] is sampled only at the clock edge that ends the last cycle of phase 5. Value 1 (signal below threshold) gives gain code 1 (gain 8) and value 0 gives code 0 (gain 1). cmp_i at any other time has no effect.
- R7: fb_x8_o[c] equals gain_o[c] during phases 6, 7 and 8 and is 0 at all other times.
- R8: gain_o keeps its captured value after the row ends, until the next accepted row start clears it to 0 in phase 0.
- R9: busy_o is high from the cycle after an accepted start through the last cycle of phase 8. A row start that arrives while busy_o is high is ignored.
- R10: sh_o is high only in phase 8, which directly follows the amplification phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_start_i | input | 1 | Row start request |
| cmp_i | input | NUM_COLS | Per-column comparator result, 1 = below threshold |
| phase_len_i | input | 9*CNT_W | Phase lengths, phase k in field k |
| pix_rst_o | output | 1 | Pixel reset strobe |
| row_sel_o | output | 1 | Row select |
| in_sw_o | output | 1 | Amplifier input switch, 1 = closed |
| tx_o | output | 1 | Transfer gate strobe |
| fb_x8_o | output | NUM_COLS | Gain-8 feedback capacitor select per column |
| sh_o | output | 1 | Sample-and-hold strobe |
| gain_o | output | NUM_COLS | Latched gain code, 1 = gain 8 |
| busy_o | output | 1 | Sequence in progress |

## Verification
Several properties are checked on every cycle. The input switch is never closed while the transfer gate is high. Row select is low when the reset strobe falls. Feedback selection only occurs with row select up and transfer off. The gain codes move only at a capture or a clear. A start request while running never restarts the sequence. The sample strobe rises only after the amplification phase. The exact cycle count of each phase, the zero-as-one rule, the single capture edge in the face of a toggling comparator, and the order of whole rows can only be shown by the bench's directed rows with their cycle-by-cycle expected strobe patterns.

// File: rtl/col_seq_pkg.sv
package col_seq_pkg;
  localparam int NUM_PH = 9;
  typedef enum logic [3:0] {
    PH_IDLE = 4'd0,
    PH_RST  = 4'd1,
    PH_GAP  = 4'd2,
    PH_SMP  = 4'd3,
    PH_ISO  = 4'd4,
    PH_TX   = 4'd5,
    PH_DEC  = 4'd6,
    PH_FB   = 4'd7,
    PH_AMP  = 4'd8,
    PH_SH   = 4'd9
  } phase_e;
endpackage

// File: rtl/col_seq_fsm.sv
module col_seq_fsm
  import col_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    row_start_i,
  input  logic [NUM_PH*CNT_W-1:0] phase_len_i,
  output phase_e                  phase_o,
  output logic                    start_o,
  output logic                    dec_last_o
);
  logic [CNT_W-1:0] load_a [NUM_PH];
  phase_e ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic last;

  // zero length behaves as one cycle
  for (genvar k = 0; k < NUM_PH; k++) begin : g_load
    assign load_a[k] = (phase_len_i[k*CNT_W +: CNT_W] == '0) ? '0
                     : phase_len_i[k*CNT_W +: CNT_W] - 1'b1;
  end

  assign last = (cnt_q == '0);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    start_o = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (row_start_i) begin
        start_o = 1'b1;
        ph_d    = PH_RST;
        cnt_d   = load_a[0];
      end
    end else if (!last) begin
      cnt_d = cnt_q - 1'b1;
    end else if (ph_q == PH_SH) begin
      ph_d = PH_IDLE;
    end else begin
      ph_d  = phase_e'(ph_q + 4'd1);
      cnt_d = load_a[int'(ph_q)];  // field of next phase = ph_q
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o    = ph_q;
  assign dec_last_o = (ph_q == PH_DEC) && last;

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE && ph_q != PH_RST && row_start_i) |=> (ph_q != PH_RST));
endmodule

// File: rtl/col_gain_latch.sv
module col_gain_latch #(
  parameter int NUM_COLS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                smp_i,
  input  logic [NUM_COLS-1:0] cmp_i,
  output logic [NUM_COLS-1:0] gain_o
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    gain_o[c] <= 1'b0;
      else if (clr_i) gain_o[c] <= 1'b0;
      else if (smp_i) gain_o[c] <= cmp_i[c];
    end
  end

  p_gain_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !smp_i) |=> $stable(gain_o));
endmodule

// File: rtl/col_strobe_decode.sv
module col_strobe_decode
  import col_seq_pkg::*;
#(
  parameter int NUM_COLS = 4
) (
  input  phase_e              phase_i,
  input  logic [NUM_COLS-1:0] gain_i,
  output logic                pix_rst_o,
  output logic                row_sel_o,
  output logic                in_sw_o,
  output logic                tx_o,
  output logic                sh_o,
  output logic                busy_o,
  output logic [NUM_COLS-1:0] fb_x8_o
);
  logic fb_en;

  always_comb begin
    pix_rst_o = (phase_i == PH_RST);
    row_sel_o = (phase_i >= PH_SMP);
    in_sw_o   = (phase_i == PH_SMP) || (phase_i == PH_AMP);
    tx_o      = (phase_i == PH_TX);
    sh_o      = (phase_i == PH_SH);
    busy_o    = (phase_i != PH_IDLE);
    fb_en     = (phase_i >= PH_FB);
    fb_x8_o   = fb_en ? gain_i : '0;
  end
endmodule

// File: rtl/col_readout_seq.sv
module col_readout_seq
  import col_seq_pkg::*;
#(
  parameter int NUM_COLS = 4,
  parameter int CNT_W    = 8,
  localparam int LEN_W   = NUM_PH * CNT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                row_start_i,
  input  logic [NUM_COLS-1:0] cmp_i,
  input  logic [LEN_W-1:0]    phase_len_i,
  output logic                pix_rst_o,
  output logic                row_sel_o,
  output logic                in_sw_o,
  output logic                tx_o,
  output logic [NUM_COLS-1:0] fb_x8_o,
  output logic                sh_o,
  output logic [NUM_COLS-1:0] gain_o,
  output logic                busy_o
);
  phase_e phase;
  logic   start, dec_last;

  col_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .row_start_i (row_start_i),
    .phase_len_i (phase_len_i),
    .phase_o     (phase),
    .start_o     (start),
    .dec_last_o  (dec_last)
  );

  col_gain_latch #(.NUM_COLS(NUM_COLS)) u_gain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .smp_i  (dec_last),
    .cmp_i  (cmp_i),
    .gain_o (gain_o)
  );

  col_strobe_decode #(.NUM_COLS(NUM_COLS)) u_dec (
    .phase_i   (phase),
    .gain_i    (gain_o),
    .pix_rst_o (pix_rst_o),
    .row_sel_o (row_sel_o),
    .in_sw_o   (in_sw_o),
    .tx_o      (tx_o),
    .sh_o      (sh_o),
    .busy_o    (busy_o),
    .fb_x8_o   (fb_x8_o)
  );

  p_iso_before_tx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_o |-> (!in_sw_o && row_sel_o));
  p_rowsel_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pix_rst_o) |-> !row_sel_o);
  p_fb_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fb_x8_o) |-> (row_sel_o && !tx_o && !pix_rst_o));
  p_sh_after_amp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh_o) |-> $past(in_sw_o));
endmodule

// File: tb/col_readout_seq_tb.sv
module col_readout_seq_tb_top;
  localparam int NC = 4;
  localparam int CW = 8;
  localparam int NP = 9;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic row_start_i = 1'b0;
  logic [NC-1:0] cmp_i = '0;
  logic [NP*CW-1:0] phase_len_i = '0;
  logic pix_rst_o, row_sel_o, in_sw_o, tx_o, sh_o, busy_o;
  logic [NC-1:0] fb_x8_o, gain_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int lens [NP];

  always #2 clk_i = ~clk_i;

  col_readout_seq #(.NUM_COLS(NC), .CNT_W(CW)) dut_i (
    .clk_i, .rst_ni, .row_start_i, .cmp_i, .phase_len_i,
    .pix_rst_o, .row_sel_o, .in_sw_o, .tx_o, .fb_x8_o, .sh_o, .gain_o, .busy_o
  );

  function automatic logic [6+2*NC-1:0] got_vec();
    return {pix_rst_o, row_sel_o, in_sw_o, tx_o, sh_o, busy_o, fb_x8_o, gain_o};
  endfunction

  // expected outputs for phase k (k = -1: idle)
  function automatic logic [6+2*NC-1:0] exp_vec(int k, logic [NC-1:0] g);
    logic [NC-1:0] gx;
    gx = (k >= 6 || k < 0) ? g : '0;
    if (k < 0)
      return {6'b0, {NC{1'b0}}, gx};
    return {k == 0, k >= 2, (k == 2 || k == 7), k == 4, k == 8, 1'b1,
            (k >= 6) ? g : {NC{1'b0}}, gx};
  endfunction

  task automatic chk(string tag, logic [6+2*NC-1:0] got, logic [6+2*NC-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic set_lens();
    for (int k = 0; k < NP; k++) phase_len_i[k*CW +: CW] = CW'(lens[k]);
  endtask

  // one row; cmp_i is inverted except on the capturing edge; ign_k: phase to
  // pulse an extra start in (-1 none)
  task automatic run_row(string tag, logic [NC-1:0] val, int ign_k);
    int eff;
    @(negedge clk_i);
    row_start_i = 1'b1;
    cmp_i = ~val;
    for (int k = 0; k < NP; k++) begin
      eff = (lens[k] == 0) ? 1 : lens[k];
      for (int i = 0; i < eff; i++) begin
        @(negedge clk_i);
        row_start_i = (k == ign_k && i == 0);
        chk($sformatf("%s phase%0d cycle%0d", tag, k, i), got_vec(), exp_vec(k, val));
        cmp_i = (k == 5 && i == eff - 1) ? val : ~val;
      end
    end
    @(negedge clk_i);
    row_start_i = 1'b0;
    chk({tag, " R9 idle after row"}, got_vec(), exp_vec(-1, val));
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", got_vec(), '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle after reset", got_vec(), '0);
  endtask

  task automatic t_basic();
    for (int k = 0; k < NP; k++) lens[k] = 2;
    set_lens();
    run_row("R2 R6 R7 basic", 4'b1010, -1);
  endtask

  task automatic t_varied();
    lens = '{1, 3, 1, 2, 4, 1, 2, 3, 1};
    set_lens();
    run_row("R3 R4 R10 varied", 4'b0101, -1);
  endtask

  task automatic t_zero();
    for (int k = 0; k < NP; k++) lens[k] = 0;
    set_lens();
    run_row("R3 zero-as-one", 4'b1111, -1);
  endtask

  task automatic t_hold();
    lens = '{2, 1, 1, 1, 1, 3, 1, 1, 2};
    set_lens();
    run_row("R8 capture", 4'b0110, -1);
    cmp_i = 4'b1001;
    repeat (5) @(negedge clk_i);
    chk("R8 held in idle", got_vec(), exp_vec(-1, 4'b0110));
    run_row("R8 cleared at start", 4'b0000, -1);
  endtask

  task automatic t_ignore();
    lens = '{1, 2, 1, 1, 3, 1, 1, 1, 2};
    set_lens();
    run_row("R9 start during transfer", 4'b1100, 4);
    run_row("R9 start during hold", 4'b0011, 8);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_varied();
    t_zero();
    t_hold();
    t_ignore();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule